// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block collects level-sensitive interrupt lines from peripherals and routes them to a small group of processors. Each source has a global enable bit and a routing word that picks the processors allowed to take it. Each processor also has its own mask over all source numbers. Software changes enables and masks by writing a source number to a dedicated set or clear address. It does not read, modify and write a bitmap.

A processor finds out what to service by reading its acknowledge register. The read returns the lowest-numbered source that is currently asserted and eligible for that processor. If there is no such source, it returns the code 1023. The read changes no state. A source stops being reported when its input line falls.

Three numbers are special:
- Numbers 0 and 1 carry per-processor summary lines from doorbell logic outside this block.
- Number 5 is a private timer line that each processor owns. It is gated only by that processor's mask.

Every bus access carries the index of the processor that issues it. That index selects which mask is written and which acknowledge value is read.

Top module: `irq_route_ctrl`

## Requirements
- R1: Writing a number n below NUM_SRC to address 0x030 sets the global enable of source n. Writing n to 0x034 clears it. Writing a number of NUM_SRC or more to either address changes nothing.
- R2: Writing n to 0x048 masks source n for the accessing processor only. Writing n to 0x04C unmasks it for that processor only. Numbers of NUM_SRC or more are ignored.
- R3: The routing word of source n is at 0x100 + 4*n. Its bit k allows processor k to take the source. It reads back with bits NUM_CPU and above as zero. Writing it in a cycle changes no other routing word.
- R4: A read of 0x044 returns, one cycle after the access, the lowest eligible source number for the accessing processor in bits [9:0], with all higher bits zero. It returns 1023 when no source is eligible.
- R5: A peripheral source n (n at least 2, n not 5) is eligible for processor k when all of these hold:
  - its line is high,
  - its global enable is set,
  - bit k of its routing word is set,
  - processor k has it unmasked.
- R6: Source 5 is eligible for processor k when that processor's own timer line is high and processor k has source 5 unmasked. The global enable, the routing word and the shared line at index 5 have no effect.
- R7: Sources 0 and 1 are eligible for processor k when processor k's inter-processor summary line (for 0) or message summary line (for 1) is high and processor k has the number unmasked. The enable, the routing word and the shared lines at indices 0 and 1 have no effect.
- R8: A read of 0x000 returns NUM_SRC in bits [11:2] and zero elsewhere.
- R9: Sources are level-sensitive. Repeated acknowledge reads return the same number while the line stays high. The number is no longer reported once the line drops.
- R10: Output cpu_irq[k] is high exactly when processor k has at least one eligible source.
- R11: After reset, all global enables are clear, all masks are set and all routing words are zero. No processor sees an interrupt until software configures the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | Index of the accessing processor |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read; held otherwise |
| irq_lines | input | NUM_SRC | Shared level interrupt lines (indices 0, 1, 5 unused) |
| timer_irq | input | NUM_CPU | Private timer line per processor |
| ipi_sum | input | NUM_CPU | Inter-processor doorbell summary per processor |
| msi_sum | input | NUM_CPU | Message doorbell summary per processor |
| cpu_irq | output | NUM_CPU | Interrupt request to each processor |

## Verification
A corrupt enable, mask or routing bit shows up at the next acknowledge read of the affected processor. That read returns a higher number than the one expected, a lower one, or 1023. At the same moment cpu_irq misbehaves: it stays low with a pending source, or it asserts with nothing eligible. Because eligibility is combinational from registered state, any error is visible in the cycle after the register write that caused it. The sweep puts one source at a time on a single processor so that each routing, enable and mask bit is observed by itself. Pseudo-random patterns then check the lowest-number-wins choice across all four processors at once.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int unsigned ID_W        = 10;
    localparam logic [9:0]  SPURIOUS_ID = 10'd1023;
    localparam int unsigned IPI_ID      = 0;
    localparam int unsigned MSI_ID      = 1;

    localparam logic [11:0] A_CTRL       = 12'h000;
    localparam logic [11:0] A_EN_SET     = 12'h030;
    localparam logic [11:0] A_EN_CLR     = 12'h034;
    localparam logic [11:0] A_ACK        = 12'h044;
    localparam logic [11:0] A_MSK_SET    = 12'h048;
    localparam logic [11:0] A_MSK_CLR    = 12'h04C;
    localparam logic [11:0] A_ROUTE_BASE = 12'h100;

    function automatic logic is_route(input logic [11:0] a, input int unsigned nsrc);
        return ({20'd0, a} >= {20'd0, A_ROUTE_BASE}) &&
               ({20'd0, a} <  {20'd0, A_ROUTE_BASE} + 32'(4 * nsrc)) &&
               (a[1:0] == 2'b00);
    endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned NUM_SRC = 32,
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [CPU_W-1:0]                  wr_cpu,
    input  logic [11:0]                       wr_addr,
    input  logic [31:0]                       wr_data,
    output logic [NUM_SRC-1:0]                en_o,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_o,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0]              en;
        logic [NUM_CPU-1:0][NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0][NUM_CPU-1:0] route;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic             num_ok;
    logic             cpu_ok;
    logic [SRC_W-1:0] num;
    logic [SRC_W-1:0] route_idx;

    assign num_ok    = wr_data < 32'(NUM_SRC);
    assign cpu_ok    = 32'(wr_cpu) < 32'(NUM_CPU);
    assign num       = wr_data[SRC_W-1:0];
    assign route_idx = SRC_W'((wr_addr - A_ROUTE_BASE) >> 2);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == A_EN_SET && num_ok) st_d.en[num] = 1'b1;
            if (wr_addr == A_EN_CLR && num_ok) st_d.en[num] = 1'b0;
            if (wr_addr == A_MSK_SET && num_ok && cpu_ok) st_d.mask[wr_cpu][num] = 1'b1;
            if (wr_addr == A_MSK_CLR && num_ok && cpu_ok) st_d.mask[wr_cpu][num] = 1'b0;
            if (is_route(wr_addr, NUM_SRC)) st_d.route[route_idx] = wr_data[NUM_CPU-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= '0;
            st_q.mask  <= '1;
            st_q.route <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign mask_o  = st_q.mask;
    assign route_o = st_q.route;

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN_SET && num_ok) |=> en_o[$past(num)]); // R1
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN_CLR && num_ok) |=> !en_o[$past(num)]); // R1
    AST_EN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !num_ok && !is_route(wr_addr, NUM_SRC)) |=> $stable(en_o) && $stable(mask_o)); // R1
    AST_MSK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MSK_SET && num_ok && cpu_ok) |=> mask_o[$past(wr_cpu)][$past(num)]); // R2
    AST_MSK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MSK_CLR && num_ok && cpu_ok) |=> !mask_o[$past(wr_cpu)][$past(num)]); // R2
    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(route_o)); // R3
endmodule

// File: rtl/irq_route_pick.sv
module irq_route_pick
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic               valid,
    output logic [ID_W-1:0]    id
);
    always_comb begin
        id = SPURIOUS_ID;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (elig[n]) id = ID_W'(n);
        end
    end

    assign valid = |elig;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int unsigned NUM_CPU  = 4,
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned TIMER_ID = 5,
    localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int unsigned SRC_W   = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [CPU_W-1:0]    bus_cpu,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_SRC-1:0]  irq_lines,
    input  logic [NUM_CPU-1:0]  timer_irq,
    input  logic [NUM_CPU-1:0]  ipi_sum,
    input  logic [NUM_CPU-1:0]  msi_sum,
    output logic [NUM_CPU-1:0]  cpu_irq
);
    logic [NUM_SRC-1:0]               en;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]  route;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]  elig;
    logic [NUM_CPU-1:0][ID_W-1:0]     ack_id;

    irq_route_regs #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_valid && bus_write),
        .wr_cpu  (bus_cpu),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .en_o    (en),
        .mask_o  (mask),
        .route_o (route)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            if (n == IPI_ID) begin : g_ipi
                assign elig[c][n] = ipi_sum[c] & ~mask[c][n];
            end else if (n == MSI_ID) begin : g_msi
                assign elig[c][n] = msi_sum[c] & ~mask[c][n];
            end else if (n == TIMER_ID) begin : g_tmr
                assign elig[c][n] = timer_irq[c] & ~mask[c][n];
            end else begin : g_per
                assign elig[c][n] = irq_lines[n] & en[n] & route[n][c] & ~mask[c][n];
            end
        end

        irq_route_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .elig  (elig[c]),
            .valid (cpu_irq[c]),
            .id    (ack_id[c])
        );

        AST_TIMER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            (!timer_irq[c] || mask[c][TIMER_ID]) |-> ack_id[c] != ID_W'(TIMER_ID)); // R6
    end

    typedef struct packed {
        logic [31:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic      cpu_ok;
    logic [SRC_W-1:0] rd_idx;

    assign cpu_ok = 32'(bus_cpu) < 32'(NUM_CPU);
    assign rd_idx = SRC_W'((bus_addr - A_ROUTE_BASE) >> 2);

    always_comb begin
        rd_d = rd_q;
        if (bus_valid && !bus_write) begin
            rd_d.rdata = '0;
            if (bus_addr == A_CTRL) begin
                rd_d.rdata[11:2] = 10'(NUM_SRC);
            end else if (bus_addr == A_ACK) begin
                rd_d.rdata[ID_W-1:0] = cpu_ok ? ack_id[bus_cpu] : SPURIOUS_ID;
            end else if (is_route(bus_addr, NUM_SRC)) begin
                rd_d.rdata[NUM_CPU-1:0] = route[rd_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    AST_ACK_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == A_ACK && cpu_ok && !cpu_irq[bus_cpu])
        |=> bus_rdata == 32'(SPURIOUS_ID)); // R4
    AST_ACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == A_ACK && cpu_ok && cpu_irq[bus_cpu])
        |=> bus_rdata < 32'(NUM_SRC)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines == '0 && timer_irq == '0 && ipi_sum == '0 && msi_sum == '0)
        |-> cpu_irq == '0); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R4
endmodule

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;
    localparam int NC = 4;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_cpu = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] lines = '0;
    logic [NC-1:0] tmr = '0;
    logic [NC-1:0] ipi = '0;
    logic [NC-1:0] msi = '0;
    logic [NC-1:0] cpu_irq;

    int checks = 0;
    int errors = 0;

    logic [NS-1:0] ref_en;
    logic [NS-1:0] ref_mask [NC];
    logic [NC-1:0] ref_route [NS];

    always #2.5 clk = ~clk;

    irq_route_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_lines(lines), .timer_irq(tmr),
        .ipi_sum(ipi), .msi_sum(msi), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input int c, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = 2'(c); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        if (d < NS) begin
            if (a == 12'h030) ref_en[d[4:0]] = 1'b1;
            if (a == 12'h034) ref_en[d[4:0]] = 1'b0;
            if (a == 12'h048) ref_mask[c][d[4:0]] = 1'b1;
            if (a == 12'h04C) ref_mask[c][d[4:0]] = 1'b0;
        end
        if (a >= 12'h100 && a < 12'h180 && a[1:0] == 2'b00) ref_route[(a - 12'h100) >> 2] = d[NC-1:0];
    endtask

    task automatic rd(input int c, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 2'(c); bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_ack(input int c);
        for (int n = 0; n < NS; n++) begin
            logic e;
            if (n == 0)      e = ipi[c] && !ref_mask[c][n];
            else if (n == 1) e = msi[c] && !ref_mask[c][n];
            else if (n == 5) e = tmr[c] && !ref_mask[c][n];
            else             e = lines[n] && ref_en[n] && ref_route[n][c] && !ref_mask[c][n];
            if (e) return 32'(n);
        end
        return 32'd1023;
    endfunction

    task automatic check_cpu(input int c, input string req);
        logic [31:0] d;
        rd(c, 12'h044, d);
        check(req, d, exp_ack(c));
        check({req, " R10"}, 32'(cpu_irq[c]), 32'(exp_ack(c) != 32'd1023));
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NC; c++) check_cpu(c, req);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] seed;
        ref_en = '0;
        for (int c = 0; c < NC; c++) ref_mask[c] = '1;
        for (int n = 0; n < NS; n++) ref_route[n] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state, nothing reaches any processor even with all lines high
        check_all("R11 idle");
        lines = '1; tmr = '1; ipi = '1; msi = '1;
        check_all("R11 masked");
        rd(0, 12'h100 + 12'(4*7), d); check("R11 route", d, 0);
        lines = '0; tmr = '0; ipi = '0; msi = '0;

        // R8: source count field
        rd(2, 12'h000, d); check("R8 ctrl", d, 32'(NS) << 2);

        // R3: routing words, upper bits dropped
        for (int n = 0; n < NS; n++) wr(n % NC, 12'h100 + 12'(4*n), 32'hFFFF_FFF0 | (32'd1 << (n % NC)));
        for (int n = 0; n < NS; n += 3) begin
            rd(1, 12'h100 + 12'(4*n), d);
            check("R3 route readback", d, 32'd1 << (n % NC));
        end

        // R2/R1: unmask everything, enable peripherals, out-of-range numbers ignored
        for (int c = 0; c < NC; c++)
            for (int n = 0; n < NS; n++) wr(c, 12'h04C, 32'(n));
        for (int n = 2; n < NS; n++) wr(0, 12'h030, 32'(n));
        wr(0, 12'h030, 32'd32);
        wr(0, 12'h034, 32'd34);
        wr(1, 12'h048, 32'd40);

        // R5: one peripheral at a time, routed to processor n%4
        for (int n = 2; n < NS; n++) begin
            if (n == 5) continue;
            lines = '0; lines[n] = 1'b1;
            check_all("R5 single source");
        end
        lines = '0;

        // R6: shared line 5 ignored; private timer per processor
        lines[5] = 1'b1; wr(0, 12'h034, 32'd5);
        check_all("R6 shared line ignored");
        tmr = 4'b1111; wr(2, 12'h048, 32'd5);
        check_all("R6 private timer");
        lines = '0; tmr = '0;

        // R7: doorbell summaries gated only by the processor's mask
        wr(0, 12'h034, 32'd0); wr(0, 12'h034, 32'd1);
        ipi = 4'b0101; msi = 4'b0111; lines[0] = 1'b1; lines[1] = 1'b1;
        wr(1, 12'h048, 32'd1);
        check_all("R7 summaries");
        wr(0, 12'h048, 32'd0);
        check_all("R7 ipi masked");
        ipi = '0; msi = '0; lines = '0;

        // R2: a mask written by one processor leaves the others alone
        lines[9] = 1'b1; wr(1, 12'h100 + 12'(4*9), 32'hF);
        wr(3, 12'h048, 32'd9);
        check_all("R2 local mask");
        lines = '0;

        // R4/R5: pseudo-random patterns, lowest number wins
        seed = 32'h1ACE_B00C;
        for (int it = 0; it < 60; it++) begin
            seed = {seed[30:0], seed[31] ^ seed[21] ^ seed[1] ^ seed[0]};
            wr(int'(seed[29:28]), seed[15] ? 12'h048 : 12'h04C, 32'(seed[20:16]));
            wr(0, 12'h100 + 12'(4 * seed[25:21]), 32'(seed[27:24]));
            if (seed[30]) wr(0, seed[14] ? 12'h034 : 12'h030, 32'(seed[13:9]));
            lines = seed ^ {seed[15:0], seed[31:16]};
            tmr = seed[3:0]; ipi = seed[7:4]; msi = seed[11:8];
            check_all("R4 random pattern");
        end
        lines = '0; tmr = '0; ipi = '0; msi = '0;

        // R1: clear enable removes a source
        wr(0, 12'h100 + 12'(4*12), 32'h1); wr(0, 12'h04C, 32'd12); wr(0, 12'h030, 32'd12);
        lines[12] = 1'b1;
        check_cpu(0, "R1 enabled");
        wr(0, 12'h034, 32'd12);
        check_cpu(0, "R1 disabled");

        // R9: no read side effect, level drop clears
        wr(0, 12'h030, 32'd12);
        rd(0, 12'h044, d); check("R9 first read", d, 12);
        rd(0, 12'h044, d); check("R9 repeat read", d, 12);
        lines[12] = 1'b0;
        rd(0, 12'h044, d); check("R9 level drop", d, 1023);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule